// File: doc/BRIEF.md
# Processor Interval Timer with Split-Word User Counter

This block is the counter/timer attached to one processor. Its counter advances one unit for every cycle in which `tick_i` is high; the surrounding logic raises `tick_i` once every 512 base clocks. Software sees the count and limit with the 9 sub-unit bits as zeros. A small word-addressed register port reads and writes four registers.

In timer mode the block is an interval timer. The count rises to a programmable limit. At that limit the count wraps to zero and a level interrupt is raised, which stays high until software reads the count register. A system configuration block drives `user_mode_i`, which switches the block into user mode. In user mode the block becomes a wide counter that software can start and stop. Its limit is written as a high word and a low word, and setting it to all ones lets the counter run freely.

Top module: `proc_ctr_timer`

## Requirements
- R1: After reset `irq_o` is low, the count is zero, the block is in timer mode and a read of register 2 returns 0x7FFFFE00 (maximum limit).
- R2: The register is selected by `addr_i[4:2]`. Selections 4 to 7 read as zero, and writes to them change nothing.
- R3: In timer mode each cycle with `tick_i` high adds one unit to the count. A read of register 0 returns the count in bits [30:9] with zeros elsewhere. A write to register 2 loads the limit from `wdata_i[30:9]` and leaves the count unchanged.
- R4: In timer mode a write to register 0 loads the limit from `wdata_i[30:9]`, clears the count and clears `irq_o`.
- R5: Any limit write that would give a limit of zero units stores the maximum limit of 2^22-1 units instead, in both modes. Register 2 then reads 0x7FFFFE00.
- R6: When a tick brings the count up to the limit, the count becomes zero and `irq_o` is set on the same edge. `irq_o` then stays high until register 0 is read.
- R7: A rising `user_mode_i` sets the limit to all ones, clears the count and `irq_o`, and puts the counter in the running state.
- R8: In user mode, a write to register 0 sets unit-limit bits [54:23] from `wdata_i`. A write to register 1 sets unit-limit bits [22:0] from `wdata_i[31:9]`. Each of these writes clears the count and `irq_o`. Register 0 reads count bits [54:23]. Register 1 reads count bits [22:0] placed in bits [31:9].
- R9: In user mode, a write to register 3 with bit 0 = 1 starts the counter and bit 0 = 0 stops it. A stopped counter ignores ticks. Register 3 reads the run state in bit 0.
- R10: In timer mode, writes to register 3 have no effect, register 3 reads 1, and ticks always advance the count.
- R11: A falling `user_mode_i` sets the limit to the maximum timer limit and clears the count and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one unit per high cycle |
| user_mode_i | input | 1 | User-counter mode from the system configuration block |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a register 0 read acknowledges the interrupt) |
| addr_i | input | ADDR_W | Byte address; bits [4:2] select the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a wrap in user mode. A wrap needs a limit small enough to hit within a few ticks, but entering user mode forces the limit to all ones. The stimulus therefore first writes a zero high word, which leaves only the low half set, and then writes a small low word. Both writes also clear the count. The bench then drives an exact number of ticks and checks that `irq_o` rises on the last tick. A second hard case is a limit write that does not reset the count: the bench counts partway, lowers nothing and raises the limit through register 2, then confirms that the count carried on and wrapped at the new limit.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int NREG = 4;

  typedef enum logic [2:0] {
    SEL_LIM_HI   = 3'd0,
    SEL_LIM_LO   = 3'd1,
    SEL_LIM_KEEP = 3'd2,
    SEL_RUN      = 3'd3
  } reg_sel_e;

  typedef struct packed {
    logic [NREG-1:0] wr;
    logic [NREG-1:0] rd;
  } strobe_t;
endpackage

// File: rtl/pct_decode.sv
module pct_decode #(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output pct_pkg::strobe_t  stb
);
  logic [2:0]               sel;
  logic [pct_pkg::NREG-1:0] wr_v;
  logic [pct_pkg::NREG-1:0] rd_v;

  assign sel = addr[4:2];

  for (genvar i = 0; i < pct_pkg::NREG; i++) begin : g_sel
    assign wr_v[i] = wr_en && (sel == 3'(i));
    assign rd_v[i] = rd_en && (sel == 3'(i));
  end

  assign stb = '{wr: wr_v, rd: rd_v};
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 9,
  localparam int UNIT_W = 2*DATA_W - SUB_W,
  localparam int LO_W   = DATA_W - SUB_W,
  localparam int TLIM_W = DATA_W - 1 - SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_mode_i,
  input  pct_pkg::strobe_t  stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [UNIT_W-1:0] lim,
  output logic              user_q,
  output logic              run_q,
  output logic              mode_in,
  output logic              mode_out,
  output logic              cnt_clr
);
  import pct_pkg::*;

  localparam logic [UNIT_W-1:0] TMAX_U = UNIT_W'({TLIM_W{1'b1}});

  function automatic logic [UNIT_W-1:0] fix_zero(input logic [UNIT_W-1:0] u);
    return (u == '0) ? TMAX_U : u;
  endfunction

  function automatic logic [UNIT_W-1:0] timer_units(input logic [DATA_W-1:0] w);
    return fix_zero(UNIT_W'(w[DATA_W-2:SUB_W]));
  endfunction

  logic unused_wbits;
  assign unused_wbits = ^wdata[SUB_W-1:1];

  assign mode_in  = user_mode_i & ~user_q;
  assign mode_out = ~user_mode_i & user_q;
  assign cnt_clr  = mode_in | mode_out |
                    (user_q ? (stb.wr[SEL_LIM_HI] | stb.wr[SEL_LIM_LO])
                            : stb.wr[SEL_LIM_HI]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_q <= 1'b0;
      run_q  <= 1'b1;
      lim    <= TMAX_U;
    end else begin
      user_q <= user_mode_i;
      if (mode_in) begin
        lim   <= '1;
        run_q <= 1'b1;
      end else if (mode_out) begin
        lim   <= TMAX_U;
        run_q <= 1'b1;
      end else if (user_q) begin
        if (stb.wr[SEL_LIM_HI])
          lim <= fix_zero({wdata, lim[LO_W-1:0]});
        else if (stb.wr[SEL_LIM_LO])
          lim <= fix_zero({lim[UNIT_W-1:LO_W], wdata[DATA_W-1:SUB_W]});
        if (stb.wr[SEL_RUN])
          run_q <= wdata[0];
      end else if (stb.wr[SEL_LIM_HI] || stb.wr[SEL_LIM_KEEP]) begin
        lim <= timer_units(wdata);
      end
    end
  end

  // R7
  entry_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_in |=> (lim == '1) && run_q && user_q);

  // R10
  timer_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_q && !user_mode_i && stb.wr[SEL_RUN]) |=> run_q);

  // R11
  exit_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out |=> (lim == TMAX_U) && !user_q);

  // R5
  lim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wr != '0) |=> (lim != '0));
endmodule

// File: rtl/pct_count.sv
module pct_count #(
  parameter int UNIT_W = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              clr_i,
  input  logic              ack_i,
  input  logic [UNIT_W-1:0] lim,
  output logic [UNIT_W-1:0] cnt,
  output logic              irq,
  output logic              wrap_evt
);
  function automatic logic [UNIT_W:0] step(input logic [UNIT_W-1:0] c);
    return {1'b0, c} + (UNIT_W+1)'(1);
  endfunction

  logic [UNIT_W:0] nxt;
  assign nxt      = step(cnt);
  assign wrap_evt = tick_en && !clr_i && (nxt >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (clr_i) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (wrap_evt)     cnt <= '0;
      else if (tick_en) cnt <= nxt[UNIT_W-1:0];
      if (wrap_evt)     irq <= 1'b1;
      else if (ack_i)   irq <= 1'b0;
    end
  end

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0) && irq);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wrap_evt));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0) && !irq);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr_i) |=> $stable(cnt));
endmodule

// File: rtl/proc_ctr_timer.sv
module proc_ctr_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int SUB_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              user_mode_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import pct_pkg::*;

  localparam int UNIT_W = 2*DATA_W - SUB_W;
  localparam int LO_W   = DATA_W - SUB_W;
  localparam int TLIM_W = DATA_W - 1 - SUB_W;

  function automatic logic [DATA_W-1:0] fmt_timer(input logic [UNIT_W-1:0] u);
    return {1'b0, u[TLIM_W-1:0], {SUB_W{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] fmt_low(input logic [UNIT_W-1:0] u);
    return {u[LO_W-1:0], {SUB_W{1'b0}}};
  endfunction

  strobe_t           stb;
  logic [UNIT_W-1:0] lim;
  logic [UNIT_W-1:0] cnt;
  logic              user_q, run_q, mode_in, mode_out, cnt_clr;
  logic              tick_en, wrap_evt;

  pct_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i), .stb(stb)
  );

  pct_ctrl #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode_i), .stb(stb),
    .wdata(wdata_i), .lim(lim), .user_q(user_q), .run_q(run_q),
    .mode_in(mode_in), .mode_out(mode_out), .cnt_clr(cnt_clr)
  );

  assign tick_en = tick_i && (!user_q || run_q);

  pct_count #(.UNIT_W(UNIT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr_i(cnt_clr),
    .ack_i(stb.rd[SEL_LIM_HI]), .lim(lim), .cnt(cnt), .irq(irq_o),
    .wrap_evt(wrap_evt)
  );

  logic unused_misc;
  assign unused_misc = ^{addr_i[1:0], lim[UNIT_W-1:TLIM_W], mode_out};

  always_comb begin
    unique case (reg_sel_e'(addr_i[4:2]))
      SEL_LIM_HI:   rdata_o = user_q ? cnt[UNIT_W-1:LO_W] : fmt_timer(cnt);
      SEL_LIM_LO:   rdata_o = user_q ? fmt_low(cnt) : '0;
      SEL_LIM_KEEP: rdata_o = fmt_timer(lim);
      SEL_RUN:      rdata_o = DATA_W'(run_q);
      default:      rdata_o = '0;
    endcase
  end

  // R9
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && user_mode_i && !run_q && !cnt_clr) |=> $stable(cnt));

  // R8
  user_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && user_mode_i && (stb.wr[SEL_LIM_HI] || stb.wr[SEL_LIM_LO]))
      |=> (cnt == '0) && !irq_o);

  // R7
  entry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_in |=> !irq_o && (cnt == '0));

  // R2
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i[4] && !mode_in && !mode_out) |=> $stable(lim));
endmodule

// File: tb/proc_ctr_timer_bench.sv
module proc_ctr_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        user_mode_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  proc_ctr_timer u_proc_ctr_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .user_mode_i(user_mode_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  localparam logic [31:0] MAXRD = 32'h7FFF_FE00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    user_mode_i = m;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq_o), 0);
    rd(5'h00, d); chk("R1 count", d, 0);
    rd(5'h08, d); chk("R1 limit", d, MAXRD);
    rd(5'h0C, d); chk("R1 timer mode run", d, 1);
  endtask

  task automatic t_interval;
    logic [31:0] d;
    wr(5'h00, 32'h0000_0A00);
    ticks(4);
    chk("R6 no irq before limit", 32'(irq_o), 0);
    rd(5'h00, d); chk("R3 count 4", d, 32'h800);
    ticks(1);
    chk("R6 irq at limit", 32'(irq_o), 1);
    repeat (3) @(negedge clk);
    chk("R6 irq level held", 32'(irq_o), 1);
    rd(5'h00, d); chk("R6 wrapped count", d, 0);
    @(negedge clk);
    chk("R6 irq acked by read", 32'(irq_o), 0);
  endtask

  task automatic t_keep_limit;
    logic [31:0] d;
    ticks(3);
    wr(5'h08, 32'h0000_1400);
    rd(5'h00, d); chk("R3 count kept on reg2 write", d, 32'h600);
    ticks(6);
    chk("R3 no irq at 9 of 10", 32'(irq_o), 0);
    ticks(1);
    chk("R3 irq at new limit", 32'(irq_o), 1);
    wr(5'h00, 32'h0000_0A00);
    chk("R4 irq cleared by reg0 write", 32'(irq_o), 0);
    ticks(2);
    wr(5'h00, 32'h0000_0A00);
    rd(5'h00, d); chk("R4 count cleared by reg0 write", d, 0);
  endtask

  task automatic t_zero_and_run;
    logic [31:0] d;
    wr(5'h00, 32'h0000_01FF);
    rd(5'h08, d); chk("R5 zero limit becomes max", d, MAXRD);
    wr(5'h0C, 32'h0);
    rd(5'h0C, d); chk("R10 reg3 ignored in timer mode", d, 1);
    ticks(2);
    rd(5'h00, d); chk("R10 counts after stop write", d, 32'h400);
  endtask

  task automatic t_user;
    logic [31:0] d;
    wr(5'h00, 32'h0000_0400);
    ticks(2);
    chk("R7 irq set before entry", 32'(irq_o), 1);
    set_mode(1'b1);
    chk("R7 irq cleared on entry", 32'(irq_o), 0);
    rd(5'h00, d); chk("R7 high count zero", d, 0);
    rd(5'h04, d); chk("R7 low count zero", d, 0);
    rd(5'h08, d); chk("R7 limit all ones", d, MAXRD);
    ticks(3);
    rd(5'h04, d); chk("R8 low count 3", d, 32'h600);
    wr(5'h0C, 32'h0);
    rd(5'h0C, d); chk("R9 run reads 0", d, 0);
    ticks(3);
    rd(5'h04, d); chk("R9 stopped count held", d, 32'h600);
    wr(5'h0C, 32'h1);
    ticks(2);
    rd(5'h04, d); chk("R9 restarted count", d, 32'hA00);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0000_0800);
    ticks(3);
    chk("R8 no irq at 3 of 4", 32'(irq_o), 0);
    ticks(1);
    chk("R8 irq at split limit", 32'(irq_o), 1);
    rd(5'h00, d); chk("R8 high count after wrap", d, 0);
    @(negedge clk);
    chk("R8 irq acked", 32'(irq_o), 0);
    ticks(2);
    wr(5'h00, 32'h1);
    rd(5'h04, d); chk("R8 high write clears count", d, 0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    rd(5'h08, d); chk("R5 user zero limit becomes max", d, MAXRD);
  endtask

  task automatic t_exit;
    logic [31:0] d;
    wr(5'h04, 32'h0000_0600);
    ticks(3);
    chk("R11 irq set before exit", 32'(irq_o), 1);
    set_mode(1'b0);
    chk("R11 irq cleared on exit", 32'(irq_o), 0);
    rd(5'h08, d); chk("R11 limit max", d, MAXRD);
    rd(5'h00, d); chk("R11 count zero", d, 0);
    ticks(2);
    wr(5'h10, 32'h0000_0800);
    wr(5'h1C, 32'h0);
    rd(5'h08, d); chk("R2 unmapped write ignored", d, MAXRD);
    rd(5'h14, d); chk("R2 unmapped read zero", d, 0);
    rd(5'h00, d); chk("R2 count unchanged", d, 32'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval();
    t_keep_limit();
    t_zero_and_run();
    t_user();
    t_exit();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule